// File: doc/BRIEF.md
# Prioritised Backplane Interrupt Requester

This block lets a board module raise an interrupt on one of seven active-low request lines of an asynchronous backplane. A single-cycle local event pulse arms a request at the configured level. The interrupt handler then runs an acknowledge cycle. The acknowledge arrives through the daisy-chain input. The block either answers it with its configured 8-bit identification vector, or hands it on to the next slot.

Two release policies are available, and a configuration bit selects between them. With release on acknowledge, the request line drops as soon as the block hands out its vector. With release on register access, the line stays low after the acknowledge and drops only when local logic pulses a clear strobe, for example after software has read a status register. All backplane strobes are sampled on the local clock, and every output comes straight from a register.

Top module: `bus_interrupter`

## Requirements
- R1: During and after reset, every request line, the chain output and the data-acknowledge output are high, and the data bus is not driven.
- R2: An event pulse with level L in 1..7 pulls request line L (bit L-1 of `irq_n`) low one cycle later, and all other request lines stay high. An event pulse with level 0 has no effect. At most one request line is ever low.
- R3: A further event while a request is pending changes nothing: the line and the level stay as they were. One release clears the request, and a later acknowledge cycle at that level is passed on.
- R4: The block responds when it samples acknowledge, address strobe and chain input all low, with `ack_lvl` equal to its pending level. It then keeps the chain output high. Once it has sampled `ds0_n` low, it drives `dtack_n` low, `data_oe` high and `data_out` equal to the configured vector on the next cycle.
- R5: The cycle after `ds0_n` is sampled high, `dtack_n` returns high and `data_oe` returns low.
- R6: If the block is not pending, or is pending at another level, it pulls `iack_out_n` low in the cycle after it samples the acknowledge condition. `iack_out_n` returns high in the cycle after `iack_in_n` is sampled high.
- R7: With `cfg_roak` = 1, the request line is released on the same edge that pulls `dtack_n` low.
- R8: With `cfg_roak` = 0, the request line stays low through the acknowledge cycle. A `reg_clr` pulse releases it one cycle later. With `cfg_roak` = 1, `reg_clr` has no effect.
- R9: An event in the same cycle as a release (either policy) leaves the request asserted.
- R10: `iack_out_n` and `dtack_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | 1 | Local event pulse |
| cfg_level | input | 3 | Request level 1..7, 0 disables |
| cfg_vector | input | 8 | Identification vector |
| cfg_roak | input | 1 | 1: release on acknowledge, 0: release on clear strobe |
| reg_clr | input | 1 | Register-access clear strobe |
| irq_n | output | 7 | Request lines, bit i is level i+1, active low |
| iack_n | input | 1 | Acknowledge cycle marker, active low |
| iack_in_n | input | 1 | Daisy-chain input, active low |
| iack_out_n | output | 1 | Daisy-chain output, active low |
| as_n | input | 1 | Address strobe, active low |
| ds0_n | input | 1 | Data strobe, active low |
| ack_lvl | input | 3 | Level being acknowledged (address lines 3..1) |
| data_out | output | 8 | Vector returned on the data bus |
| data_oe | output | 1 | Data bus drive enable |
| dtack_n | output | 1 | Data acknowledge, active low |

## Verification
Two functions can land on the same clock edge: a new local event, and the release of the current request. The release comes either from the acknowledge handshake pulling `dtack_n` low, or from the clear strobe. The bench provokes both collisions on purpose. It raises `evt` in the very cycle that `ds0_n` first goes low, and in a separate case it raises `evt` together with `reg_clr`. In each case it judges the request line one cycle later, and expects it still to be low. Randomised rounds add acknowledges at matching, mismatching and unused levels under both policies.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W   = 3;
    localparam int NUM_LVL = (1 << LVL_W) - 1;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_PASS,
        CH_ARM,
        CH_DRIVE,
        CH_HOLD
    } chain_st_t;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] lvl;
    } req_t;

    // Active-high line mask for a pending request
    function automatic logic [NUM_LVL-1:0] req_lines(input req_t r);
        logic [NUM_LVL-1:0] m;
        for (int i = 0; i < NUM_LVL; i++)
            m[i] = r.valid && (r.lvl == LVL_W'(i + 1));
        return m;
    endfunction
endpackage

// File: rtl/irq_request.sv
module irq_request
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               evt,
    input  logic [LVL_W-1:0]   cfg_level,
    input  logic               cfg_roak,
    input  logic               reg_clr,
    input  logic               ack_release,
    output req_t               req,
    output logic [NUM_LVL-1:0] irq_n
);
    logic set_c, clr_c;

    assign set_c = evt && (cfg_level != '0);
    assign clr_c = cfg_roak ? ack_release : reg_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= '0;
        end else if (set_c) begin
            // set wins over a simultaneous release; a pending request keeps its level
            if (!req.valid) begin
                req.valid <= 1'b1;
                req.lvl   <= cfg_level;
            end
        end else if (clr_c) begin
            req.valid <= 1'b0;
        end
    end

    assign irq_n = ~req_lines(req);
endmodule

// File: rtl/irq_chain.sv
module irq_chain
    import irq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iack_n,
    input  logic             iack_in_n,
    input  logic             as_n,
    input  logic             ds0_n,
    input  logic [LVL_W-1:0] ack_lvl,
    input  req_t             req,
    input  logic [VEC_W-1:0] cfg_vector,
    output logic             iack_out_n,
    output logic             dtack_n,
    output logic             data_oe,
    output logic [VEC_W-1:0] data_out,
    output logic             ack_release
);
    chain_st_t st, st_nx;
    logic [VEC_W-1:0] vec_q;
    logic ack_seen, mine;

    assign ack_seen    = !iack_n && !iack_in_n && !as_n;
    assign mine        = req.valid && (req.lvl == ack_lvl);
    assign ack_release = (st == CH_ARM) && !iack_in_n && !ds0_n;

    always_comb begin
        st_nx = st;
        case (st)
            CH_IDLE:  if (ack_seen) st_nx = mine ? CH_ARM : CH_PASS;
            CH_PASS:  if (iack_in_n) st_nx = CH_IDLE;
            CH_ARM:   if (iack_in_n) st_nx = CH_IDLE;
                      else if (!ds0_n) st_nx = CH_DRIVE;
            CH_DRIVE: if (iack_in_n) st_nx = CH_IDLE;
                      else if (ds0_n) st_nx = CH_HOLD;
            CH_HOLD:  if (iack_in_n) st_nx = CH_IDLE;
            default:  st_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= CH_IDLE;
            vec_q <= '0;
        end else begin
            st <= st_nx;
            if (ack_release) vec_q <= cfg_vector;
        end
    end

    assign iack_out_n = (st != CH_PASS);
    assign dtack_n    = (st != CH_DRIVE);
    assign data_oe    = (st == CH_DRIVE);
    assign data_out   = (st == CH_DRIVE) ? vec_q : '0;
endmodule

// File: rtl/bus_interrupter.sv
module bus_interrupter
    import irq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt,
    input  logic [LVL_W-1:0]   cfg_level,
    input  logic [VEC_W-1:0]   cfg_vector,
    input  logic               cfg_roak,
    input  logic               reg_clr,
    output logic [NUM_LVL-1:0] irq_n,
    input  logic               iack_n,
    input  logic               iack_in_n,
    output logic               iack_out_n,
    input  logic               as_n,
    input  logic               ds0_n,
    input  logic [LVL_W-1:0]   ack_lvl,
    output logic [VEC_W-1:0]   data_out,
    output logic               data_oe,
    output logic               dtack_n
);
    req_t req;
    logic ack_release;

    irq_request u_req (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .cfg_level   (cfg_level),
        .cfg_roak    (cfg_roak),
        .reg_clr     (reg_clr),
        .ack_release (ack_release),
        .req         (req),
        .irq_n       (irq_n)
    );

    irq_chain #(.VEC_W(VEC_W)) u_chain (
        .clk         (clk),
        .rst         (rst),
        .iack_n      (iack_n),
        .iack_in_n   (iack_in_n),
        .as_n        (as_n),
        .ds0_n       (ds0_n),
        .ack_lvl     (ack_lvl),
        .req         (req),
        .cfg_vector  (cfg_vector),
        .iack_out_n  (iack_out_n),
        .dtack_n     (dtack_n),
        .data_oe     (data_oe),
        .data_out    (data_out),
        .ack_release (ack_release)
    );
endmodule

// File: rtl/bus_interrupter_chk.sv
module bus_interrupter_chk
    import irq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               evt,
    input logic               cfg_roak,
    input logic               reg_clr,
    input logic [NUM_LVL-1:0] irq_n,
    input logic               iack_in_n,
    input logic               iack_out_n,
    input logic               ds0_n,
    input logic               data_oe,
    input logic               dtack_n
);
    assert_one_line_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(~irq_n) <= 1);

    assert_vector_driven_R4: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> data_oe);

    assert_ack_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (!dtack_n && ds0_n) |=> dtack_n);

    assert_chain_end_R6: assert property (@(posedge clk) disable iff (rst)
        iack_in_n |=> iack_out_n);

    assert_roak_release_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(dtack_n) && $past(cfg_roak) && !$past(evt)) |-> (&irq_n));

    assert_rora_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_roak) && !$past(reg_clr) && !(&$past(irq_n))) |-> (irq_n == $past(irq_n)));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(!iack_out_n && !dtack_n));
endmodule

bind bus_interrupter bus_interrupter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .cfg_roak   (cfg_roak),
    .reg_clr    (reg_clr),
    .irq_n      (irq_n),
    .iack_in_n  (iack_in_n),
    .iack_out_n (iack_out_n),
    .ds0_n      (ds0_n),
    .data_oe    (data_oe),
    .dtack_n    (dtack_n)
);

// File: tb/tb_bus_interrupter.sv
`timescale 1ns/1ps
module tb_bus_interrupter;
    logic       clk = 1'b0;
    logic       rst, evt, cfg_roak, reg_clr;
    logic [2:0] cfg_level, ack_lvl;
    logic [7:0] cfg_vector, data_out;
    logic [6:0] irq_n;
    logic       iack_n, iack_in_n, iack_out_n, as_n, ds0_n, data_oe, dtack_n;

    int total = 0;
    int bad   = 0;
    logic       mpend = 1'b0;
    logic [2:0] mlvl  = 3'd0;

    always #5 clk = ~clk;

    bus_interrupter dut (
        .clk(clk), .rst(rst), .evt(evt), .cfg_level(cfg_level), .cfg_vector(cfg_vector),
        .cfg_roak(cfg_roak), .reg_clr(reg_clr), .irq_n(irq_n), .iack_n(iack_n),
        .iack_in_n(iack_in_n), .iack_out_n(iack_out_n), .as_n(as_n), .ds0_n(ds0_n),
        .ack_lvl(ack_lvl), .data_out(data_out), .data_oe(data_oe), .dtack_n(dtack_n)
    );

    function automatic logic [6:0] exp_irq(input logic p, input logic [2:0] l);
        logic [6:0] v = 7'h7F;
        if (p && l != 0) v[l-1] = 1'b0;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic post_event(input logic [2:0] l, input string tag);
        evt = 1'b1; cfg_level = l;
        tick;
        evt = 1'b0;
        if (l != 0 && !mpend) begin mpend = 1'b1; mlvl = l; end
        chk(tag, 32'(irq_n), 32'(exp_irq(mpend, mlvl)));
    endtask

    task automatic iack_cycle(input logic [2:0] a);
        logic resp;
        iack_n = 1'b0; as_n = 1'b0; ack_lvl = a; iack_in_n = 1'b0;
        tick;
        resp = mpend && (mlvl == a);
        if (!resp) begin
            chk("R6 pass", 32'(iack_out_n), 32'd0);
            iack_in_n = 1'b1; iack_n = 1'b1; as_n = 1'b1;
            tick;
            chk("R6 chain end", 32'(iack_out_n), 32'd1);
            return;
        end
        chk("R4 no pass", 32'(iack_out_n), 32'd1);
        chk("R4 wait ds", 32'(dtack_n), 32'd1);
        ds0_n = 1'b0;
        tick;
        chk("R4 dtack", 32'(dtack_n), 32'd0);
        chk("R4 vector", 32'(data_out), 32'(cfg_vector));
        chk("R4 oe", 32'(data_oe), 32'd1);
        if (cfg_roak) mpend = 1'b0;
        chk(cfg_roak ? "R7 roak release" : "R8 rora hold", 32'(irq_n), 32'(exp_irq(mpend, mlvl)));
        ds0_n = 1'b1;
        tick;
        chk("R5 dtack off", 32'(dtack_n), 32'd1);
        chk("R5 oe off", 32'(data_oe), 32'd0);
        iack_in_n = 1'b1; iack_n = 1'b1; as_n = 1'b1;
        tick;
        chk("R10 chain idle", 32'(iack_out_n), 32'd1);
    endtask

    task automatic clear_pulse(input string tag);
        reg_clr = 1'b1;
        tick;
        reg_clr = 1'b0;
        if (!cfg_roak) mpend = 1'b0;
        chk(tag, 32'(irq_n), 32'(exp_irq(mpend, mlvl)));
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; evt = 1'b0; cfg_level = 3'd0; cfg_vector = 8'h00; cfg_roak = 1'b1;
        reg_clr = 1'b0; iack_n = 1'b1; iack_in_n = 1'b1; as_n = 1'b1; ds0_n = 1'b1; ack_lvl = 3'd0;
        repeat (3) tick;
        rst = 1'b0;
        tick;
        chk("R1 irq", 32'(irq_n), 32'h7F);
        chk("R1 iack_out", 32'(iack_out_n), 32'd1);
        chk("R1 dtack", 32'(dtack_n), 32'd1);
        chk("R1 oe", 32'(data_oe), 32'd0);

        // level 0 disabled, then an acknowledge with nothing pending
        post_event(3'd0, "R2 level0");
        iack_cycle(3'd4);

        // duplicate event, release on acknowledge, second acknowledge passes
        cfg_roak = 1'b1; cfg_vector = 8'hA5;
        post_event(3'd5, "R2 raise");
        post_event(3'd2, "R3 dup");
        iack_cycle(3'd2);
        iack_cycle(3'd5);
        iack_cycle(3'd5);
        chk("R3 cleared", 32'(irq_n), 32'h7F);

        // clear strobe ignored when releasing on acknowledge
        post_event(3'd7, "R2 raise7");
        clear_pulse("R8 roak ignores clr");
        iack_cycle(3'd7);

        // release on register access
        cfg_roak = 1'b0; cfg_vector = 8'h3C;
        post_event(3'd1, "R2 raise1");
        iack_cycle(3'd1);
        clear_pulse("R8 rora clear");

        // event collides with acknowledge release
        cfg_roak = 1'b1; cfg_vector = 8'h81;
        post_event(3'd3, "R2 raise3");
        iack_n = 1'b0; as_n = 1'b0; ack_lvl = 3'd3; iack_in_n = 1'b0;
        tick;
        ds0_n = 1'b0; evt = 1'b1; cfg_level = 3'd3;
        tick;
        evt = 1'b0;
        chk("R9 ack+evt dtack", 32'(dtack_n), 32'd0);
        chk("R9 ack+evt irq", 32'(irq_n), 32'(exp_irq(1'b1, 3'd3)));
        ds0_n = 1'b1;
        tick;
        iack_in_n = 1'b1; iack_n = 1'b1; as_n = 1'b1;
        tick;

        // event collides with clear strobe
        cfg_roak = 1'b0;
        reg_clr = 1'b1; evt = 1'b1; cfg_level = 3'd3;
        tick;
        reg_clr = 1'b0; evt = 1'b0;
        chk("R9 clr+evt irq", 32'(irq_n), 32'(exp_irq(1'b1, 3'd3)));
        clear_pulse("R8 final clear");

        // randomised rounds
        for (int k = 0; k < 40; k++) begin
            logic [2:0] l, l2, a;
            l  = 3'(1 + ($urandom % 7));
            l2 = 3'($urandom % 8);
            a  = 3'($urandom % 8);
            cfg_vector = 8'($urandom);
            cfg_roak   = 1'($urandom % 2);
            post_event(l, "R2 rand raise");
            if ($urandom % 2 == 0) post_event(l2, "R3 rand dup");
            if ($urandom % 2 == 0) a = l;
            iack_cycle(a);
            cfg_roak = 1'b0;
            clear_pulse("R8 rand clear");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule